// File: doc/BRIEF.md
# Tagged Index Register Address Unit

This unit holds the index registers of a 36-bit word machine and turns each instruction's address field Y and 3-bit tag into a 15-bit effective address. The index is subtracted from Y, and the subtraction wraps modulo 2^15. The unit has two modes. In legacy (multiple-tag) mode each tag bit reaches one register, and several bits may be set together; their contents are ORed. In extended mode the tag value names one of seven registers.

The sequencer presents one operation per cycle. It can be an ordinary memory reference, an index-register load, or a command that enters or leaves legacy mode. The effective address is combinational from the current register contents. Register writes and mode changes take effect at the next clock edge. When a memory reference carries the indirect flag, the unit raises a request. The sequencer then fetches the indirect word and presents its tag and Y as a fresh operation, which is indexed again.

Top module: `idx_addr_unit`

## Requirements
- R1: After reset the unit is in legacy mode (`mode_multi_o` = 1) and all seven index registers hold zero, so every tag yields an effective address equal to Y.
- R2: For a memory reference (`op_kind_i` = 0) the effective address is (Y − C(T)) mod 2^15.
- R3: A tag of zero gives C(T) = 0 in both modes.
- R4: In legacy mode, tag bit k (k = 0, 1, 2) selects register number 2^k (registers 1, 2 and 4), and C(T) is the bitwise OR of all selected registers.
- R5: In extended mode, C(T) is the content of the register whose number equals the tag value (1 to 7).
- R6: In legacy mode a load (`op_kind_i` = 1) writes `load_data_i` into every register selected by a set tag bit, and leaves the other registers unchanged.
- R7: In extended mode a load writes only the register named by the tag value; a tag of zero writes nothing.
- R8: For loads and mode commands (`op_kind_i` = 1, 2, 3) the effective address is Y, with no indexing.
- R9: The leave command (`op_kind_i` = 3) switches to extended mode and the enter command (`op_kind_i` = 2) switches to legacy mode, both from the next cycle. No other operation changes the mode.
- R10: `indirect_o` is 1 exactly when a valid memory reference has `flag_i` = 2'b11.
- R11: When a load and an address computation fall in the same cycle, the address uses the register values from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_kind_i | input | 2 | 0 memory reference, 1 index load, 2 enter legacy mode, 3 leave legacy mode |
| tag_i | input | 3 | Tag field |
| y_i | input | 15 | Address field Y |
| flag_i | input | 2 | Flag field; 2'b11 requests indirection |
| load_data_i | input | 15 | Value for an index load |
| ea_o | output | 15 | Effective address |
| indirect_o | output | 1 | Indirect-addressing request to the sequencer |
| mode_multi_o | output | 1 | 1 in legacy (multiple-tag) mode |

## Verification
The effective address and the indirect request are combinational, so they are due in the same cycle as the operation. The bench drives each operation just after a falling edge and compares these outputs one time unit later, before the rising edge. Register loads and mode changes become visible one cycle later. The bench's model applies them only after the rising edge, and the next operation's address and the mode output are compared against that updated model. This ordering also covers the same-cycle load case, where the expected address comes from the register values before the load.

// File: rtl/idx_pkg.sv
package idx_pkg;
    localparam int ADDR_W = 15;
    localparam int TAG_W  = 3;
    localparam int NREG   = (1 << TAG_W) - 1;

    typedef enum logic [1:0] {
        OP_MEM   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_ENTER = 2'd2,
        OP_LEAVE = 2'd3
    } op_kind_t;

    typedef enum logic {
        ST_MULTI  = 1'b0,
        ST_SINGLE = 1'b1
    } mode_t;
endpackage

// File: rtl/idx_mode_fsm.sv
module idx_mode_fsm
    import idx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  op_kind_t op_kind,
    output mode_t    mode
);
    mode_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MULTI;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MULTI:  if (op_valid && op_kind == OP_LEAVE) state_d = ST_SINGLE;
            ST_SINGLE: if (op_valid && op_kind == OP_ENTER) state_d = ST_MULTI;
            default:   state_d = ST_MULTI;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/idx_regfile.sv
module idx_regfile
    import idx_pkg::*;
#(
    parameter int W  = ADDR_W,
    parameter int TW = TAG_W,
    parameter int N  = (1 << TW) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  mode_t              mode,
    input  logic [TW-1:0]      tag,
    input  logic [W-1:0]       wdata,
    output logic [N-1:0][W-1:0] regs
);
    for (genvar i = 1; i <= N; i++) begin : g_reg
        localparam logic [TW-1:0] NUM = TW'(i);
        localparam bit IS_POW2 = ($countones(i) == 1);
        logic hit;

        always_comb begin
            hit = 1'b0;
            unique case (mode)
                ST_MULTI:  hit = IS_POW2 && ((NUM & tag) != '0);
                ST_SINGLE: hit = (tag == NUM);
                default:   hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n)            regs[i-1] <= '0;
            else if (wr_en && hit) regs[i-1] <= wdata;
        end
    end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
    import idx_pkg::*;
#(
    parameter int W  = ADDR_W,
    parameter int TW = TAG_W,
    parameter int N  = (1 << TW) - 1
) (
    input  mode_t               mode,
    input  logic                use_index,
    input  logic [TW-1:0]       tag,
    input  logic [W-1:0]        y,
    input  logic [N-1:0][W-1:0] regs,
    output logic [W-1:0]        ea
);
    logic [TW-1:0][W-1:0] multi_terms;
    logic [W-1:0] multi_or, single_sel, ct;

    for (genvar k = 0; k < TW; k++) begin : g_term
        assign multi_terms[k] = tag[k] ? regs[(1 << k) - 1] : '0;
    end

    always_comb begin
        multi_or = '0;
        for (int k = 0; k < TW; k++) multi_or = multi_or | multi_terms[k];
        single_sel = (tag == '0) ? '0 : regs[tag - TW'(1)];
        ct = '0;
        unique case (mode)
            ST_MULTI:  ct = multi_or;
            ST_SINGLE: ct = single_sel;
            default:   ct = '0;
        endcase
        ea = use_index ? (y - ct) : y;
    end
endmodule

// File: rtl/idx_addr_unit.sv
module idx_addr_unit
    import idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [1:0]        op_kind_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [ADDR_W-1:0] y_i,
    input  logic [1:0]        flag_i,
    input  logic [ADDR_W-1:0] load_data_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              indirect_o,
    output logic              mode_multi_o
);
    op_kind_t kind;
    mode_t    mode;
    logic     is_mem;
    logic [NREG-1:0][ADDR_W-1:0] regs;

    assign kind   = op_kind_t'(op_kind_i);
    assign is_mem = op_valid_i && (kind == OP_MEM);

    idx_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid_i),
        .op_kind  (kind),
        .mode     (mode)
    );

    idx_regfile #(.W(ADDR_W), .TW(TAG_W), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (op_valid_i && (kind == OP_LOAD)),
        .mode  (mode),
        .tag   (tag_i),
        .wdata (load_data_i),
        .regs  (regs)
    );

    idx_ea_calc #(.W(ADDR_W), .TW(TAG_W), .N(NREG)) u_ea (
        .mode      (mode),
        .use_index (is_mem),
        .tag       (tag_i),
        .y         (y_i),
        .regs      (regs),
        .ea        (ea_o)
    );

    assign indirect_o   = is_mem && (flag_i == 2'b11);
    assign mode_multi_o = (mode == ST_MULTI);
endmodule

// File: rtl/idx_addr_unit_chk.sv
module idx_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid_i,
    input logic [1:0]  op_kind_i,
    input logic [2:0]  tag_i,
    input logic [14:0] y_i,
    input logic [1:0]  flag_i,
    input logic [14:0] ea_o,
    input logic        indirect_o,
    input logic        mode_multi_o
);
    logic was_reset;
    always_ff @(posedge clk) was_reset <= !rst_n;

    p_reset_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_reset |-> mode_multi_o);
    p_tag_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && tag_i == 3'd0) |-> (ea_o == y_i));
    p_ctrl_noidx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i != 2'd0) |-> (ea_o == y_i));
    p_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == 2'd3) |=> !mode_multi_o);
    p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == 2'd2) |=> mode_multi_o);
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid_i && op_kind_i[1]) |=> $stable(mode_multi_o));
    p_indirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        indirect_o == (op_valid_i && op_kind_i == 2'd0 && flag_i == 2'b11));
endmodule

bind idx_addr_unit idx_addr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .op_kind_i    (op_kind_i),
    .tag_i        (tag_i),
    .y_i          (y_i),
    .flag_i       (flag_i),
    .ea_o         (ea_o),
    .indirect_o   (indirect_o),
    .mode_multi_o (mode_multi_o)
);

// File: tb/sim_idx_addr_unit.sv
module sim_idx_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [1:0]  op_kind_i = 2'd0;
    logic [2:0]  tag_i = 3'd0;
    logic [14:0] y_i = '0;
    logic [1:0]  flag_i = 2'd0;
    logic [14:0] load_data_i = '0;
    logic [14:0] ea_o;
    logic        indirect_o, mode_multi_o;

    int checks = 0;
    int fails = 0;
    logic [14:0] m_reg [1:7];
    bit m_multi;

    always #5 clk = ~clk;

    idx_addr_unit u0 (.*);

    function automatic logic [14:0] ct_of(input logic [2:0] t);
        logic [14:0] c = '0;
        if (m_multi) begin
            if (t[0]) c |= m_reg[1];
            if (t[1]) c |= m_reg[2];
            if (t[2]) c |= m_reg[4];
        end else if (t != 0) c = m_reg[t];
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [2:0] t, input logic [14:0] y,
                        input logic [1:0] f, input logic [14:0] d, input string req);
        logic [14:0] exp_ea;
        @(negedge clk);
        chk("R9 mode", 32'(mode_multi_o), 32'(m_multi));
        op_valid_i = 1'b1; op_kind_i = k; tag_i = t; y_i = y; flag_i = f; load_data_i = d;
        #1;
        exp_ea = (k == 2'd0) ? (y - ct_of(t)) : y;  // R2 R8 R11: old values
        chk(req, 32'(ea_o), 32'(exp_ea));
        chk("R10 indirect", 32'(indirect_o), 32'(k == 2'd0 && f == 2'b11));
        @(posedge clk);
        if (k == 2'd1) begin
            if (m_multi) begin
                for (int b = 0; b < 3; b++) if (t[b]) m_reg[1 << b] = d;
            end else if (t != 0) m_reg[t] = d;
        end
        if (k == 2'd2) m_multi = 1'b1;
        if (k == 2'd3) m_multi = 1'b0;
        #1 op_valid_i = 1'b0;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 1; i <= 7; i++) m_reg[i] = '0;
        m_multi = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 mode", 32'(mode_multi_o), 32'd1);
        step(2'd0, 3'd7, 15'h1234, 2'd0, '0, "R1 ea after reset");
        // R3 tag zero
        step(2'd0, 3'd0, 15'h0042, 2'd3, '0, "R3 tag zero");
        // R6 multi load all three, R11 same-cycle uses old value
        step(2'd1, 3'd7, 15'h0100, 2'd0, 15'h00F0, "R8 load ea");
        step(2'd0, 3'd1, 15'h0100, 2'd0, '0, "R6 reg1");
        step(2'd0, 3'd4, 15'h0100, 2'd0, '0, "R6 reg4");
        step(2'd1, 3'd2, 15'h0000, 2'd0, 15'h000F, "R8 load ea");
        step(2'd0, 3'd3, 15'h0000, 2'd0, '0, "R4 or wrap R2");
        // R9 leave, R5 single select, R6 reg3 untouched
        step(2'd3, 3'd5, 15'h0777, 2'd0, '0, "R8 leave ea");
        step(2'd0, 3'd3, 15'h0010, 2'd0, '0, "R6 reg3 unwritten");
        step(2'd1, 3'd6, 15'h0010, 2'd0, 15'h0003, "R7 load6");
        step(2'd0, 3'd6, 15'h0010, 2'd0, '0, "R5 reg6");
        step(2'd1, 3'd0, 15'h0010, 2'd0, 15'h7FFF, "R7 tag0 no write");
        step(2'd0, 3'd0, 15'h0010, 2'd0, '0, "R3 tag zero single");
        step(2'd0, 3'd2, 15'h0010, 2'd0, '0, "R7 reg2 kept");
        // R11 load then read in same cycle
        step(2'd1, 3'd2, 15'h0020, 2'd0, 15'h0001, "R11 load ea");
        step(2'd0, 3'd2, 15'h0020, 2'd3, '0, "R11 new value next cycle");
        step(2'd2, 3'd1, 15'h0020, 2'd0, '0, "R8 enter ea");
        step(2'd0, 3'd6, 15'h0020, 2'd0, '0, "R4 after enter");
        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic [1:0] k;
            k = ($urandom % 8 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
            step(k, 3'($urandom), 15'($urandom), 2'($urandom), 15'($urandom), "R2 R4 R5 R6 R7 random");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule